// File: doc/BRIEF.md
# Multi-Lane Serial Flash Command Front-End

This block is the device-side front end of a serial flash port. It runs directly on the serial clock, with chip select high acting as its session reset. After chip select goes low it collects a one-byte opcode, decodes it, and then takes the address, any dummy clocks and the data phase. Each phase runs on one, two or four data lines, depending on the selected protocol and on the opcode. Reads present an address and a byte request to an external memory model and shift the returned byte out on falling clock edges. Programs report each received byte with its address. A read mode that skips the opcode goes straight from address to dummy clocks to data.

The state machine has the states ST_OPC (opcode collection), ST_ADDR (address collection), ST_DUMMY (dummy clock count), ST_DOUT (read data out), ST_DIN (program data in), ST_HOLD (command with no further phase) and ST_IGN (unknown opcode, silent). Its transitions are:
- reset → ST_OPC, or → ST_ADDR when opcode-less reads are enabled.
- ST_OPC → ST_ADDR, ST_HOLD or ST_IGN on the last opcode bit.
- ST_ADDR → ST_DIN for a program. Otherwise it goes → ST_DUMMY if the dummy count is not zero, and → ST_DOUT if it is.
- ST_DUMMY → ST_DOUT after the last dummy clock.
- ST_DOUT, ST_DIN, ST_HOLD and ST_IGN hold until chip select rises.

Top module: `sflash_frontend`

## Requirements
- R1: While rst_n is low or cs_n is high, dq_oe is 0, cmd_valid is 0, rd_req is 0 and wr_valid is 0. A new transaction starts at the first rising sclk edge after cs_n falls.
- R2: The opcode is taken MSB first. After its last bit, cmd_valid is 1, cmd_op holds the opcode and cmd_kind holds its class (1 read, 2 program, 3 control). All three hold until cs_n rises.
- R3: proto_sel is taken while cs_n is high: 0 or 3 is extended (opcode on dq[0]), 1 is dual and 2 is quad. In dual mode every phase uses dq[1:0], with dq[1] carrying the earlier bit. In quad mode every phase uses dq[3:0], with dq[3] carrying the earliest bit.
- R4: In extended mode the lanes are set by the opcode as (address/data). 03, 13, 0B, 0C and 02 use 1/1. 3B and 3C use 1/2. BB and BC use 2/2. 6B and 6C use 1/4. EB and EC use 4/4.
- R5: Opcodes 13, 0C, 3C, BC, 6C and EC take a 4-byte address. All other addressed opcodes take 3 bytes. After the last address bit, addr holds the address, and its upper byte is 0 for a 3-byte address.
- R6: The number of dummy clocks between address and data is 0 for 03, 13 and 02, 10 for EB and EC, and 8 for the other reads.
- R7: Read data leaves MSB first and changes on falling sclk edges. The lanes are dq[1] for one lane, dq[1:0] for two and dq[3:0] for four. dq_oe is 0010, 0011 or 1111 to match, and it is non-zero only in the data-out phase.
- R8: With cs_n held low, reads continue with addr+1 after each full byte. A 3-byte address wraps from FFFFFF to 0.
- R9: With xip_en high while cs_n is high, no opcode is taken. A 3-byte address is taken on four lanes, followed by xip_dummy dummy clocks and quad data. cmd_valid is 1, cmd_kind is 1 and cmd_op is 0.
- R10: Opcode 02 takes a 3-byte address, then data bytes on the data lanes. For each byte, wr_valid is 1 for one cycle with wr_data holding the byte and addr holding the base address plus the byte index.
- R11: After an unknown opcode, cmd_valid stays 0 and dq_oe stays 0 until cs_n rises. The next transaction decodes normally.
- R12: Raising cs_n in any phase ends the transaction. The next transaction starts from the opcode.
- R13: Opcode 06 raises cmd_valid with cmd_kind 3 and takes no further phase: dq_oe stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock |
| rst_n | input | 1 | Power-on reset, active low |
| cs_n | input | 1 | Chip select, active low |
| proto_sel | input | 2 | Protocol: 0/3 extended, 1 dual, 2 quad |
| xip_en | input | 1 | Opcode-less read mode enable |
| xip_dummy | input | DUMMY_W | Dummy clocks in opcode-less mode |
| dq_in | input | 4 | Data lines, input side |
| dq_out | output | 4 | Data lines, output side |
| dq_oe | output | 4 | Per-lane output enable |
| cmd_valid | output | 1 | Decoded command valid |
| cmd_kind | output | 2 | Command class |
| cmd_op | output | 8 | Received opcode |
| addr | output | 32 | Current address |
| rd_req | output | 1 | Byte fetch request at addr |
| rd_data | input | 8 | Byte returned for addr |
| wr_valid | output | 1 | Program byte strobe |
| wr_data | output | 8 | Program byte |

## Verification
During a continuous read, the rising edge that completes a byte also increments the address. The falling edge right after it must fetch and drive the next byte from the new address. Multi-byte reads on one, two and four lanes therefore cross byte boundaries on every lane width, including the wrap of a 3-byte address. Each returned byte is compared with the bench memory at the address that the bench itself has advanced. A cs_n rise that lands in the middle of the address phase, or in the middle of a data byte, is judged by the quiet outputs that follow and by a clean decode of the next opcode.

// File: rtl/sfe_pkg.sv
`timescale 1ns/1ps
package sfe_pkg;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 6;

    typedef enum logic [2:0] {
        ST_OPC, ST_ADDR, ST_DUMMY, ST_DOUT, ST_DIN, ST_HOLD, ST_IGN
    } sfe_state_t;

    typedef enum logic [1:0] {
        K_NONE = 2'd0, K_READ = 2'd1, K_PROG = 2'd2, K_CTRL = 2'd3
    } sfe_kind_t;

    typedef struct packed {
        logic      known;
        logic      has_addr;
        sfe_kind_t kind;
        logic [1:0] alog;
        logic [1:0] dlog;
        logic      a4;
    } sfe_dec_t;

    // lane count as log2: 0 -> one lane, 1 -> two, 2 -> four
    function automatic logic [1:0] lane_log(input logic [1:0] proto);
        unique case (proto)
            2'd1:    lane_log = 2'd1;
            2'd2:    lane_log = 2'd2;
            default: lane_log = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/sfe_op_decode.sv
`timescale 1ns/1ps
module sfe_op_decode
    import sfe_pkg::*;
#(
    parameter int DUMMY_W    = 4,
    parameter int FAST_DUMMY = 8,
    parameter int QIO_DUMMY  = 10
) (
    input  logic [7:0]         op,
    input  logic [1:0]         proto,
    output sfe_dec_t           dec,
    output logic [DUMMY_W-1:0] dummy
);

    logic [1:0] plog;
    assign plog = lane_log(proto);

    always_comb begin
        dec   = '{known: 1'b0, has_addr: 1'b0, kind: K_NONE,
                  alog: 2'd0, dlog: 2'd0, a4: 1'b0};
        dummy = '0;
        case (op)
            8'h03, 8'h13: begin
                dec.known = 1'b1; dec.has_addr = 1'b1; dec.kind = K_READ;
                dec.a4 = (op == 8'h13);
            end
            8'h0B, 8'h0C: begin
                dec.known = 1'b1; dec.has_addr = 1'b1; dec.kind = K_READ;
                dec.a4 = op[2]; dummy = DUMMY_W'(FAST_DUMMY);
            end
            8'h3B, 8'h3C: begin
                dec.known = 1'b1; dec.has_addr = 1'b1; dec.kind = K_READ;
                dec.a4 = op[2]; dec.dlog = 2'd1; dummy = DUMMY_W'(FAST_DUMMY);
            end
            8'hBB, 8'hBC: begin
                dec.known = 1'b1; dec.has_addr = 1'b1; dec.kind = K_READ;
                dec.a4 = op[2]; dec.alog = 2'd1; dec.dlog = 2'd1;
                dummy = DUMMY_W'(FAST_DUMMY);
            end
            8'h6B, 8'h6C: begin
                dec.known = 1'b1; dec.has_addr = 1'b1; dec.kind = K_READ;
                dec.a4 = op[2]; dec.dlog = 2'd2; dummy = DUMMY_W'(FAST_DUMMY);
            end
            8'hEB, 8'hEC: begin
                dec.known = 1'b1; dec.has_addr = 1'b1; dec.kind = K_READ;
                dec.a4 = op[2]; dec.alog = 2'd2; dec.dlog = 2'd2;
                dummy = DUMMY_W'(QIO_DUMMY);
            end
            8'h02: begin
                dec.known = 1'b1; dec.has_addr = 1'b1; dec.kind = K_PROG;
            end
            8'h06: begin
                dec.known = 1'b1; dec.kind = K_CTRL;
            end
            default: ;
        endcase
        // dual and quad protocols put every phase on the protocol's lanes
        if (plog != 2'd0) begin
            dec.alog = plog;
            dec.dlog = plog;
        end
    end

endmodule

// File: rtl/sfe_fsm.sv
`timescale 1ns/1ps
module sfe_fsm
    import sfe_pkg::*;
#(
    parameter int DUMMY_W    = 4,
    parameter int FAST_DUMMY = 8,
    parameter int QIO_DUMMY  = 10
) (
    input  logic               sclk,
    input  logic               sess_rst,
    input  logic               xip_en,
    input  logic [1:0]         proto_sel,
    input  logic [DUMMY_W-1:0] xip_dummy,
    input  logic [3:0]         dq_in,
    output sfe_state_t         state,
    output logic               cmd_valid,
    output sfe_kind_t          cmd_kind,
    output logic [7:0]         cmd_op,
    output logic [ADDR_W-1:0]  addr,
    output logic [1:0]         dlog_q,
    output logic               rd_req,
    output logic               wr_valid,
    output logic [7:0]         wr_data
);

    sfe_state_t         nx_state;
    logic [1:0]         proto_q;
    logic               xip_q;
    logic [1:0]         alog_q;
    logic               a4_q;
    logic [DUMMY_W-1:0] dmy_q;
    logic [DUMMY_W-1:0] dcnt;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   cnt_nx;
    logic [CNT_W-1:0]   abits;
    logic [1:0]         cur_log;
    logic [ADDR_W-1:0]  sh;
    logic [ADDR_W-1:0]  next_sh;
    logic [ADDR_W-1:0]  addr_inc;
    logic               prog_q;
    sfe_dec_t           dec;
    logic [DUMMY_W-1:0] dec_dummy;

    sfe_op_decode #(
        .DUMMY_W(DUMMY_W), .FAST_DUMMY(FAST_DUMMY), .QIO_DUMMY(QIO_DUMMY)
    ) u_dec (
        .op(next_sh[7:0]), .proto(proto_q), .dec(dec), .dummy(dec_dummy)
    );

    always_comb begin
        unique case (state)
            ST_OPC:  cur_log = lane_log(proto_q);
            ST_ADDR: cur_log = alog_q;
            default: cur_log = dlog_q;
        endcase
    end

    always_comb begin
        unique case (cur_log)
            2'd1:    next_sh = {sh[ADDR_W-3:0], dq_in[1:0]};
            2'd2:    next_sh = {sh[ADDR_W-5:0], dq_in};
            default: next_sh = {sh[ADDR_W-2:0], dq_in[0]};
        endcase
    end

    assign cnt_nx   = cnt + (CNT_W'(1) << cur_log);
    assign abits    = a4_q ? CNT_W'(32) : CNT_W'(24);
    assign prog_q   = (cmd_kind == K_PROG);
    assign addr_inc = a4_q ? addr + 1'b1 : {8'h00, addr[23:0] + 24'd1};
    assign rd_req   = (state == ST_DOUT) && (cnt == '0);

    // next-state logic
    always_comb begin
        nx_state = state;
        unique case (state)
            ST_OPC:
                if (cnt_nx == CNT_W'(8))
                    nx_state = !dec.known ? ST_IGN
                             : (dec.has_addr ? ST_ADDR : ST_HOLD);
            ST_ADDR:
                if (cnt_nx == abits)
                    nx_state = prog_q ? ST_DIN
                             : ((dmy_q != '0) ? ST_DUMMY : ST_DOUT);
            ST_DUMMY:
                if (dcnt == dmy_q - DUMMY_W'(1)) nx_state = ST_DOUT;
            ST_DOUT, ST_DIN, ST_HOLD, ST_IGN:
                nx_state = state;
            default:
                nx_state = state;
        endcase
    end

    // state register
    always_ff @(posedge sclk or posedge sess_rst) begin
        if (sess_rst) state <= xip_en ? ST_ADDR : ST_OPC;
        else          state <= nx_state;
    end

    // datapath and outputs
    always_ff @(posedge sclk or posedge sess_rst) begin
        if (sess_rst) begin
            proto_q   <= proto_sel;
            xip_q     <= xip_en;
            alog_q    <= xip_en ? 2'd2 : lane_log(proto_sel);
            dlog_q    <= xip_en ? 2'd2 : lane_log(proto_sel);
            a4_q      <= 1'b0;
            dmy_q     <= xip_en ? xip_dummy : '0;
            dcnt      <= '0;
            cnt       <= '0;
            sh        <= '0;
            addr      <= '0;
            cmd_op    <= 8'h00;
            cmd_valid <= 1'b0;
            cmd_kind  <= K_NONE;
            wr_valid  <= 1'b0;
            wr_data   <= 8'h00;
        end else begin
            wr_valid <= 1'b0;
            unique case (state)
                ST_OPC: begin
                    sh <= next_sh;
                    if (cnt_nx == CNT_W'(8)) begin
                        cnt    <= '0;
                        cmd_op <= next_sh[7:0];
                        if (dec.known) begin
                            cmd_valid <= 1'b1;
                            cmd_kind  <= dec.kind;
                            alog_q    <= dec.alog;
                            dlog_q    <= dec.dlog;
                            a4_q      <= dec.a4;
                            dmy_q     <= dec_dummy;
                        end
                    end else begin
                        cnt <= cnt_nx;
                    end
                end
                ST_ADDR: begin
                    sh <= next_sh;
                    if (cnt_nx == abits) begin
                        cnt  <= '0;
                        addr <= a4_q ? next_sh : {8'h00, next_sh[23:0]};
                        if (xip_q) begin
                            cmd_valid <= 1'b1;
                            cmd_kind  <= K_READ;
                        end
                    end else begin
                        cnt <= cnt_nx;
                    end
                end
                ST_DUMMY: begin
                    if (dcnt == dmy_q - DUMMY_W'(1)) dcnt <= '0;
                    else                             dcnt <= dcnt + 1'b1;
                end
                ST_DOUT: begin
                    if (cnt_nx == CNT_W'(8)) begin
                        cnt  <= '0;
                        addr <= addr_inc;
                    end else begin
                        cnt <= cnt_nx;
                    end
                end
                ST_DIN: begin
                    sh <= next_sh;
                    if (wr_valid) addr <= addr_inc;
                    if (cnt_nx == CNT_W'(8)) begin
                        cnt      <= '0;
                        wr_valid <= 1'b1;
                        wr_data  <= next_sh[7:0];
                    end else begin
                        cnt <= cnt_nx;
                    end
                end
                ST_HOLD, ST_IGN: ;
                default: ;
            endcase
        end
    end

    // R5: a 3-byte address never carries an upper byte
    a_r5_addr3_upper_zero: assert property (@(posedge sclk) disable iff (sess_rst)
        !a4_q |-> (addr[31:24] == 8'h00));

    // R8: a read keeps streaming until chip select rises
    a_r8_dout_holds: assert property (@(posedge sclk) disable iff (sess_rst)
        (state == ST_DOUT) |=> (state == ST_DOUT));

    // R11: an unknown opcode keeps the block silent
    a_r11_ign_quiet: assert property (@(posedge sclk) disable iff (sess_rst)
        (state == ST_IGN) |=> ((state == ST_IGN) && !cmd_valid));

    // R2: the decoded command holds for the rest of the transaction
    a_r2_cmd_holds: assert property (@(posedge sclk) disable iff (sess_rst)
        cmd_valid |=> (cmd_valid && $stable(cmd_op)));

    // R10: each program byte moves the address on
    a_r10_wr_addr_moves: assert property (@(posedge sclk) disable iff (sess_rst)
        wr_valid |=> (addr != $past(addr)));

endmodule

// File: rtl/sfe_dout.sv
`timescale 1ns/1ps
module sfe_dout (
    input  logic       sclk,
    input  logic       sess_rst,
    input  logic       active,
    input  logic       load,
    input  logic [1:0] dlog,
    input  logic [7:0] rd_data,
    output logic [3:0] dq_out,
    output logic [3:0] dq_oe
);

    logic [7:0] obuf;
    logic [3:0] lane_mask;

    always_comb begin
        unique case (dlog)
            2'd1:    lane_mask = 4'b0011;
            2'd2:    lane_mask = 4'b1111;
            default: lane_mask = 4'b0010;
        endcase
    end

    always_ff @(negedge sclk or posedge sess_rst) begin
        if (sess_rst) begin
            obuf  <= 8'h00;
            dq_oe <= 4'h0;
        end else if (active) begin
            dq_oe <= lane_mask;
            if (load) begin
                obuf <= rd_data;
            end else begin
                unique case (dlog)
                    2'd1:    obuf <= {obuf[5:0], 2'b00};
                    2'd2:    obuf <= {obuf[3:0], 4'b0000};
                    default: obuf <= {obuf[6:0], 1'b0};
                endcase
            end
        end
    end

    always_comb begin
        unique case (dlog)
            2'd1:    dq_out = {2'b00, obuf[7:6]};
            2'd2:    dq_out = obuf[7:4];
            default: dq_out = {2'b00, obuf[7], 1'b0};
        endcase
    end

    // R7: output enables only during the data-out phase
    a_r7_oe_only_in_dout: assert property (@(posedge sclk) disable iff (sess_rst)
        (dq_oe != 4'h0) |-> active);

endmodule

// File: rtl/sflash_frontend.sv
`timescale 1ns/1ps
module sflash_frontend
    import sfe_pkg::*;
#(
    parameter int DUMMY_W    = 4,
    parameter int FAST_DUMMY = 8,
    parameter int QIO_DUMMY  = 10
) (
    input  logic               sclk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic [1:0]         proto_sel,
    input  logic               xip_en,
    input  logic [DUMMY_W-1:0] xip_dummy,
    input  logic [3:0]         dq_in,
    output logic [3:0]         dq_out,
    output logic [3:0]         dq_oe,
    output logic               cmd_valid,
    output logic [1:0]         cmd_kind,
    output logic [7:0]         cmd_op,
    output logic [31:0]        addr,
    output logic               rd_req,
    input  logic [7:0]         rd_data,
    output logic               wr_valid,
    output logic [7:0]         wr_data
);

    logic       sess_rst;
    sfe_state_t state;
    sfe_kind_t  kind_w;
    logic [1:0] dlog;

    assign sess_rst = cs_n | ~rst_n;
    assign cmd_kind = kind_w;

    sfe_fsm #(
        .DUMMY_W(DUMMY_W), .FAST_DUMMY(FAST_DUMMY), .QIO_DUMMY(QIO_DUMMY)
    ) u_fsm (
        .sclk(sclk), .sess_rst(sess_rst), .xip_en(xip_en),
        .proto_sel(proto_sel), .xip_dummy(xip_dummy), .dq_in(dq_in),
        .state(state), .cmd_valid(cmd_valid), .cmd_kind(kind_w),
        .cmd_op(cmd_op), .addr(addr), .dlog_q(dlog), .rd_req(rd_req),
        .wr_valid(wr_valid), .wr_data(wr_data)
    );

    sfe_dout u_dout (
        .sclk(sclk), .sess_rst(sess_rst), .active(state == ST_DOUT),
        .load(rd_req), .dlog(dlog), .rd_data(rd_data),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

endmodule

// File: tb/sflash_frontend_test.sv
`timescale 1ns/1ps
module sflash_frontend_test;

    logic        sclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic [1:0]  proto_sel = 2'd0;
    logic        xip_en = 1'b0;
    logic [3:0]  xip_dummy = 4'd0;
    logic [3:0]  dq_in = 4'h0;
    logic [3:0]  dq_out, dq_oe;
    logic        cmd_valid, rd_req, wr_valid;
    logic [1:0]  cmd_kind;
    logic [7:0]  cmd_op, rd_data, wr_data;
    logic [31:0] addr;
    int          nchk = 0;
    int          nfail = 0;
    bit          done = 0;

    always #5 sclk = ~sclk;

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'hA5;
    endfunction

    assign rd_data = mem_byte(addr);

    sflash_frontend uut (
        .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .proto_sel(proto_sel),
        .xip_en(xip_en), .xip_dummy(xip_dummy), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_op(cmd_op), .addr(addr), .rd_req(rd_req),
        .rd_data(rd_data), .wr_valid(wr_valid), .wr_data(wr_data)
    );

    // expected behaviour from the requirements
    function automatic int plane(input int p);
        return (p == 1) ? 2 : ((p == 2) ? 4 : 1);
    endfunction
    function automatic int alanes(input logic [7:0] op, input int p);
        if (p == 1 || p == 2) return plane(p);
        if (op == 8'hBB || op == 8'hBC) return 2;
        if (op == 8'hEB || op == 8'hEC) return 4;
        return 1;
    endfunction
    function automatic int dlanes(input logic [7:0] op, input int p);
        if (p == 1 || p == 2) return plane(p);
        if (op inside {8'h3B, 8'h3C, 8'hBB, 8'hBC}) return 2;
        if (op inside {8'h6B, 8'h6C, 8'hEB, 8'hEC}) return 4;
        return 1;
    endfunction
    function automatic int abytes(input logic [7:0] op);
        return (op inside {8'h13, 8'h0C, 8'h3C, 8'hBC, 8'h6C, 8'hEC}) ? 4 : 3;
    endfunction
    function automatic int ndummy(input logic [7:0] op);
        if (op inside {8'h03, 8'h13, 8'h02}) return 0;
        if (op inside {8'hEB, 8'hEC}) return 10;
        return 8;
    endfunction
    function automatic logic [3:0] omask(input int ln);
        return (ln == 1) ? 4'b0010 : ((ln == 2) ? 4'b0011 : 4'b1111);
    endfunction
    function automatic logic [31:0] next_a(input logic [31:0] a, input bit a4);
        return a4 ? a + 1 : {8'h00, a[23:0] + 24'd1};
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [3:0] g);
        dq_in = g;
        @(negedge sclk);
    endtask

    task automatic send(input logic [31:0] v, input int nbits, input int ln);
        for (int i = nbits / ln - 1; i >= 0; i--) begin
            logic [3:0] g;
            g = 4'((v >> (i * ln)) & ((1 << ln) - 1));
            put(g);
        end
    endtask

    task automatic start();
        @(negedge sclk);
        cs_n = 1'b0;
    endtask

    task automatic stop();
        @(negedge sclk);
        cs_n  = 1'b1;
        dq_in = 4'h0;
        repeat (2) @(negedge sclk);
    endtask

    task automatic read_bytes(input int n, input int ln, input logic [31:0] a0,
                              input bit a4);
        logic [31:0] ea;
        ea = a0;
        for (int k = 0; k < n; k++) begin
            logic [7:0] b;
            b = 8'h00;
            for (int g = 0; g < 8 / ln; g++) begin
                logic [3:0] grp;
                @(posedge sclk);
                grp = (ln == 1) ? {3'b000, dq_out[1]}
                    : ((ln == 2) ? {2'b00, dq_out[1:0]} : dq_out);
                if (g == 0) chk(dq_oe == omask(ln), "R7 oe lanes", dq_oe, omask(ln));
                b = 8'((b << ln) | grp);
            end
            if (k == 0) chk(b == mem_byte(ea), "R4/R7 first byte", b, mem_byte(ea));
            else        chk(b == mem_byte(ea), "R8 next byte", b, mem_byte(ea));
            ea = next_a(ea, a4);
        end
    endtask

    task automatic do_read(input logic [7:0] op, input int p,
                           input logic [31:0] a, input int n);
        logic [31:0] ea;
        proto_sel = 2'(p);
        xip_en    = 1'b0;
        start();
        send({24'h0, op}, 8, plane(p));
        chk(cmd_valid && cmd_op == op && cmd_kind == 2'd1, "R2/R3 opcode",
            {cmd_valid, cmd_kind, cmd_op}, {1'b1, 2'd1, op});
        send(a, abytes(op) * 8, alanes(op, p));
        ea = (abytes(op) == 4) ? a : {8'h00, a[23:0]};
        chk(addr == ea, "R5 address", addr, ea);
        for (int i = 0; i < ndummy(op); i++) begin
            put(4'h0);
            chk(dq_oe == 4'h0, "R6 dummy quiet", dq_oe, 0);
        end
        read_bytes(n, dlanes(op, p), ea, abytes(op) == 4);
        stop();
    endtask

    task automatic do_xip(input logic [23:0] a, input logic [3:0] d, input int n);
        proto_sel = 2'($urandom % 4);
        xip_en    = 1'b1;
        xip_dummy = d;
        start();
        send({8'h00, a}, 24, 4);
        chk(cmd_valid && cmd_kind == 2'd1 && cmd_op == 8'h00 && addr == {8'h00, a},
            "R9 no-opcode read", addr, {8'h00, a});
        for (int i = 0; i < d; i++) begin
            put(4'h0);
            chk(dq_oe == 4'h0, "R9 dummy quiet", dq_oe, 0);
        end
        read_bytes(n, 4, {8'h00, a}, 1'b0);
        stop();
        xip_en = 1'b0;
    endtask

    task automatic do_prog(input int p, input logic [23:0] a, input int n);
        proto_sel = 2'(p);
        start();
        send(32'h02, 8, plane(p));
        chk(cmd_valid && cmd_kind == 2'd2, "R10 program kind", cmd_kind, 2);
        send({8'h00, a}, 24, plane(p));
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = 8'($urandom);
            send({24'h0, d}, 8, plane(p));
            chk(wr_valid && wr_data == d && addr == {8'h00, a} + k,
                "R10 program byte", {wr_valid, wr_data, addr[22:0]},
                {1'b1, d, 23'(a + k)});
            chk(dq_oe == 4'h0, "R10 no drive", dq_oe, 0);
        end
        stop();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    logic [7:0] ops [12] = '{8'h03, 8'h13, 8'h0B, 8'h0C, 8'h3B, 8'h3C,
                             8'hBB, 8'hBC, 8'h6B, 8'h6C, 8'hEB, 8'hEC};

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge sclk);
        chk(dq_oe == 0 && !cmd_valid && !rd_req && !wr_valid, "R1 reset idle",
            {dq_oe, cmd_valid, rd_req, wr_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge sclk);
        chk(dq_oe == 0 && !cmd_valid, "R1 cs high idle", {dq_oe, cmd_valid}, 0);

        // directed reads on each lane arrangement
        do_read(8'h03, 0, 32'h0012_3456, 3);
        do_read(8'h13, 0, 32'hDEAD_BEEF, 2);
        do_read(8'h3B, 0, 32'h0000_0FF0, 2);
        do_read(8'hBC, 0, 32'h1234_5678, 2);
        do_read(8'h6B, 0, 32'h00AB_CDEF, 2);
        do_read(8'hEB, 0, 32'h0055_AA00, 3);
        do_read(8'h03, 1, 32'h0001_0203, 2);
        do_read(8'h0B, 2, 32'h0070_8090, 2);
        do_read(8'hEC, 3, 32'h89AB_CDEF, 2);
        // R8 address wrap, 3-byte and 4-byte
        do_read(8'h03, 0, 32'h00FF_FFFF, 2);
        do_read(8'h6C, 0, 32'hFFFF_FFFF, 2);

        // R13 control command
        proto_sel = 2'd0;
        start();
        send(32'h06, 8, 1);
        chk(cmd_valid && cmd_kind == 2'd3 && cmd_op == 8'h06, "R13 control",
            {cmd_kind, cmd_op}, {2'd3, 8'h06});
        repeat (8) put(4'hF);
        chk(dq_oe == 0, "R13 no drive", dq_oe, 0);
        stop();

        // R11 unknown opcode in extended and quad
        for (int p = 0; p < 3; p += 2) begin
            proto_sel = 2'(p);
            start();
            send(32'hFF, 8, plane(p));
            for (int i = 0; i < 16; i++) begin
                put(4'($urandom));
                chk(dq_oe == 0 && !cmd_valid, "R11 silent", {dq_oe, cmd_valid}, 0);
            end
            stop();
            do_read(8'h0B, p, 32'h0033_4455, 1);
        end

        // R12 abort in the address phase and in the data phase
        proto_sel = 2'd0;
        start();
        send(32'h0B, 8, 1);
        send(32'h0000_0ABC, 12, 1);
        stop();
        chk(!cmd_valid && dq_oe == 0 && !rd_req, "R12 abort addr",
            {cmd_valid, dq_oe, rd_req}, 0);
        do_read(8'h03, 0, 32'h0044_0011, 1);
        start();
        send(32'h03, 8, 1);
        send(32'h0000_1000, 24, 1);
        repeat (3) @(posedge sclk);
        stop();
        chk(!cmd_valid && dq_oe == 0, "R12 abort data", {cmd_valid, dq_oe}, 0);
        do_read(8'hEB, 0, 32'h0000_0100, 1);

        // R9 opcode-less reads
        do_xip(24'h12_3456, 4'd6, 2);
        do_xip(24'hFF_FFFF, 4'd0, 2);
        do_xip(24'h00_0010, 4'd15, 1);

        // R10 program on each protocol
        do_prog(0, 24'h10_2000, 3);
        do_prog(1, 24'h00_4500, 2);
        do_prog(2, 24'h7F_FF00, 4);

        // random mix
        for (int t = 0; t < 40; t++) begin
            logic [7:0] op;
            op = ops[$urandom % 12];
            do_read(op, int'($urandom % 4), $urandom, 1 + int'($urandom % 4));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule